// File: doc/BRIEF.md
# Pin Controller with Edge Interrupts

This block controls ten general-purpose pins from a byte-wide register bus. Each pin can be an output or an input. An output pin drives its pad from a data bit, either push-pull or open drain. A level input copies its synchronised pad level into the data bit. An edge input raises a sticky status bit on a rising edge, or on either edge. Software clears a status bit by writing a one to it. A per-pin enable decides which status bits reach the single interrupt line.

Every control is a 16-bit image split across two byte addresses, with the low byte at the even address. The pin controls sit in bits [10:1] of the image, with pin n at bit n+1. Bit 0 and bits [15:11] read as zero and ignore writes. The bus reads combinationally and writes on the clock edge when `we_i` is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the direction, data, input-mode, enable and status registers read as zero. The edge-select and output-mode registers read 0x07FE (low byte 0xFE, high byte 0x07).
- R2: The byte map is: direction 0x20/0x21, data 0x22/0x23, input mode 0x24/0x25, enable 0x26/0x27, edge select 0x28/0x29, status 0x2A/0x2B, output mode 0x2C/0x2D. Pin n sits at image bit n+1. Image bits 0 and [15:11] read 0 and writes to them are dropped.
- R3: With direction bit 1 (output) and output-mode bit 0 (push-pull), `pad_o` equals the data bit and `pad_oe_o` is 1.
- R4: With direction bit 1 and output-mode bit 1 (open drain), `pad_o` is 0 and `pad_oe_o` is the inverse of the data bit.
- R5: With direction bit 0 (input), `pad_oe_o` and `pad_o` are 0.
- R6: For an input with input-mode bit 0 (level), the data bit takes the pad level on the third rising clock edge after the pad changes, and not before.
- R7: For an input with input-mode bit 1 (edge) and edge-select bit 0, a rising pad edge sets the status bit at the third clock edge after the change. A falling edge does not set it.
- R8: For an edge-mode input with edge-select bit 1, both rising and falling pad edges set the status bit.
- R9: Output pins and level-mode inputs never set status bits.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: When an edge event and a clearing write land on the same status bit in the same cycle, the bit stays set.
- R12: `irq_o` is 1 exactly when some status bit is set and its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for `addr_i` |
| pad_i | input | 10 | Pad input levels |
| pad_o | output | 10 | Pad output values |
| pad_oe_o | output | 10 | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench times a clearing write so that it lands in the same cycle as a fresh edge event. A design that lets the clear win loses that event. It samples a level input one cycle before and at the expected latency, which catches a synchroniser that is too short or too long. It drives falling edges in rising-only mode and toggles output and level-mode pins, which exposes status bits set by the wrong events. It also writes only one byte of the status register, so a design that clears the other byte's bits, or treats a written 0 as a clear, fails.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int IMG_W = 16;
  localparam int NREG  = 7;
  typedef enum logic [2:0] {
    REG_DIR   = 3'd0,
    REG_DAT   = 3'd1,
    REG_IMODE = 3'd2,
    REG_IEN   = 3'd3,
    REG_IEDGE = 3'd4,
    REG_STAT  = 3'd5,
    REG_OMODE = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int NPIN = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] sync_i,
  input  logic [NPIN-1:0] dir_i,
  input  logic [NPIN-1:0] imode_i,
  input  logic [NPIN-1:0] iedge_i,
  output logic [NPIN-1:0] evt_o
);
  logic [NPIN-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  logic [NPIN-1:0] rise, fall;
  assign rise  = sync_i & ~prev_q;
  assign fall  = ~sync_i & prev_q;
  // only edge-mode inputs produce events
  assign evt_o = ~dir_i & imode_i & (rise | (fall & iedge_i));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int          NPIN = 10,
  parameter logic [7:0]  BASE = 8'h20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      addr_i,
  input  logic [7:0]      wdata_i,
  input  logic            we_i,
  input  logic [NPIN-1:0] sync_i,
  input  logic [NPIN-1:0] evt_i,
  output logic [NPIN-1:0] dir_o,
  output logic [NPIN-1:0] dat_o,
  output logic [NPIN-1:0] imode_o,
  output logic [NPIN-1:0] ien_o,
  output logic [NPIN-1:0] iedge_o,
  output logic [NPIN-1:0] stat_o,
  output logic [NPIN-1:0] omode_o,
  output logic [NPIN-1:0] clr_o,
  output logic [7:0]      rdata_o
);
  localparam logic [7:0] SPAN = 8'(2 * NREG);

  logic [7:0] off;
  logic       hit, hi;
  logic [2:0] idx;
  assign off = addr_i - BASE;
  assign hit = off < SPAN;
  assign hi  = off[0];
  assign idx = off[3:1];

  function automatic logic [NPIN-1:0] merge(logic [NPIN-1:0] cur, logic h, logic [7:0] wd);
    logic [IMG_W-1:0] im;
    im = '0;
    im[NPIN:1] = cur;
    if (h) im[15:8] = wd;
    else   im[7:0]  = wd;
    return im[NPIN:1];
  endfunction

  logic [NPIN-1:0] regs [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [NPIN-1:0] RST =
      (k == REG_IEDGE || k == REG_OMODE) ? '1 : '0;
    logic            wr;
    logic [NPIN-1:0] q, d;
    assign wr = we_i & hit & (idx == 3'(k));

    if (k == REG_STAT) begin : g_w1c
      logic [NPIN-1:0] clr;
      assign clr   = wr ? merge('0, hi, wdata_i) : '0;
      assign d     = (q & ~clr) | evt_i;  // event beats clear
      assign clr_o = clr;
    end else if (k == REG_DAT) begin : g_dat
      logic [NPIN-1:0] flw, wv;
      assign flw = ~dir_o & ~imode_o;
      assign wv  = wr ? merge(q, hi, wdata_i) : q;
      assign d   = (wv & ~flw) | (sync_i & flw);
    end else begin : g_plain
      assign d = wr ? merge(q, hi, wdata_i) : q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST;
      else         q <= d;
    end
    assign regs[k] = q;
  end

  assign dir_o   = regs[REG_DIR];
  assign dat_o   = regs[REG_DAT];
  assign imode_o = regs[REG_IMODE];
  assign ien_o   = regs[REG_IEN];
  assign iedge_o = regs[REG_IEDGE];
  assign stat_o  = regs[REG_STAT];
  assign omode_o = regs[REG_OMODE];

  logic [IMG_W-1:0] rimg;
  always_comb begin
    rimg = '0;
    if (hit && idx < 3'(NREG)) rimg[NPIN:1] = regs[idx];
    rdata_o = hi ? rimg[15:8] : rimg[7:0];
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int         NPIN = 10,
  parameter logic [7:0] BASE = 8'h20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      addr_i,
  input  logic [7:0]      wdata_i,
  input  logic            we_i,
  output logic [7:0]      rdata_o,
  input  logic [NPIN-1:0] pad_i,
  output logic [NPIN-1:0] pad_o,
  output logic [NPIN-1:0] pad_oe_o,
  output logic            irq_o
);
  logic [NPIN-1:0] sync, evt, clr;
  logic [NPIN-1:0] dir_q, dat_q, imode_q, ien_q, iedge_q, stat_q, omode_q;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(sync)
  );

  gpio_edge_det #(.NPIN(NPIN)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .dir_i(dir_q),
    .imode_i(imode_q), .iedge_i(iedge_q), .evt_o(evt)
  );

  gpio_regfile #(.NPIN(NPIN), .BASE(BASE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .sync_i(sync), .evt_i(evt), .dir_o(dir_q), .dat_o(dat_q),
    .imode_o(imode_q), .ien_o(ien_q), .iedge_o(iedge_q), .stat_o(stat_q),
    .omode_o(omode_q), .clr_o(clr), .rdata_o(rdata_o)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pad
    always_comb begin
      if (!dir_q[i]) begin
        pad_o[i]    = 1'b0;
        pad_oe_o[i] = 1'b0;
      end else if (omode_q[i]) begin
        pad_o[i]    = 1'b0;       // open drain: drive low only
        pad_oe_o[i] = ~dat_q[i];
      end else begin
        pad_o[i]    = dat_q[i];
        pad_oe_o[i] = 1'b1;
      end
    end
  end

  assign irq_o = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPIN = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NPIN-1:0] dir,
  input logic [NPIN-1:0] imode,
  input logic [NPIN-1:0] omode,
  input logic [NPIN-1:0] stat,
  input logic [NPIN-1:0] evt,
  input logic [NPIN-1:0] clr,
  input logic [NPIN-1:0] pad_o,
  input logic [NPIN-1:0] pad_oe_o
);
  a_r4_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir & omode & pad_o) == '0);

  a_r5_input_not_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~dir & pad_oe_o) == '0);

  a_r9_no_event_level_or_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt & (dir | ~imode)) == '0);

  a_r11_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

  a_r10_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr & ~evt) != '0) |=> ((stat & $past(clr & ~evt)) == '0));

  a_r7_set_only_by_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dir(dir_q), .imode(imode_q),
  .omode(omode_q), .stat(stat_q), .evt(evt), .clr(clr),
  .pad_o(pad_o), .pad_oe_o(pad_oe_o)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [7:0]      addr_i = '0, wdata_i = '0;
  logic            we_i = 1'b0;
  logic [7:0]      rdata_o;
  logic [NPIN-1:0] pad_i = '0, pad_o, pad_oe_o;
  logic            irq_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  gpio_irq_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] img(logic [NPIN-1:0] v);
    logic [15:0] r;
    r = '0;
    r[NPIN:1] = v;
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic wr16(logic [7:0] a, logic [15:0] d);
    wr(a, d[7:0]);
    wr(a + 8'd1, d[15:8]);
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
  endtask

  task automatic rd16(logic [7:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 8'd1, hi);
    d = {hi, lo};
  endtask

  task automatic done();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x0001 expected 0x0000");
    done();
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  b;
    logic [NPIN-1:0] v, p, q, exp_st;
    void'($urandom(32'd1234));

    tick(2);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset values
    for (int a = 0; a < 7; a++) begin
      rd16(8'h20 + 8'(2 * a), r);
      check("R1", r, (a == 4 || a == 6) ? 16'h07FE : 16'h0000);
    end
    check("R1 irq", {15'b0, irq_o}, 16'h0);
    check("R5 oe", {6'b0, pad_oe_o}, 16'h0);

    // R2 reserved bits dropped
    wr16(8'h20, 16'hFFFF);
    rd16(8'h20, r);
    check("R2 reserved", r, 16'h07FE);
    rd(8'h2E, b);
    check("R2 unmapped", {8'h0, b}, 16'h0);

    // R3 push-pull outputs
    wr16(8'h2C, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      v = NPIN'($urandom);
      wr16(8'h22, img(v));
      check("R3 pad_o", {6'b0, pad_o}, {6'b0, v});
      check("R3 oe", {6'b0, pad_oe_o}, 16'h03FF);
    end

    // R4 open drain
    wr16(8'h2C, 16'hFFFF);
    for (int i = 0; i < 4; i++) begin
      v = NPIN'($urandom);
      wr16(8'h22, img(v));
      check("R4 pad_o", {6'b0, pad_o}, 16'h0);
      check("R4 oe", {6'b0, pad_oe_o}, {6'b0, ~v});
    end

    // R9 output pins toggling raise no status
    wr16(8'h24, 16'hFFFF);
    pad_i = '1; tick(4); pad_i = '0; tick(4);
    rd16(8'h2A, r);
    check("R9 output", r, 16'h0);

    // R5 inputs, R6 level follow
    wr16(8'h24, 16'h0000);
    wr16(8'h20, 16'h0000);
    check("R5 oe", {6'b0, pad_oe_o}, 16'h0);
    check("R5 pad_o", {6'b0, pad_o}, 16'h0);
    for (int i = 0; i < 4; i++) begin
      p = NPIN'($urandom);
      pad_i = p; tick(4);
      rd16(8'h22, r);
      check("R6 follow", r, img(p));
    end
    pad_i = '0; tick(4);
    pad_i[0] = 1'b1;
    tick(2);
    rd(8'h22, b);  // sampled before third edge
    check("R6 early", {8'h0, b}, 16'h0000);
    rd(8'h22, b);
    check("R6 on time", {8'h0, b}, 16'h0002);
    rd16(8'h2A, r);
    check("R9 level", r, 16'h0);

    // R7 rising only
    pad_i = '0; tick(4);
    wr16(8'h24, 16'hFFFF);
    wr16(8'h28, 16'h0000);
    pad_i = 10'h155; tick(3);
    rd16(8'h2A, r);
    check("R7 rise", r, img(10'h155));
    check("R12 masked", {15'b0, irq_o}, 16'h0);
    wr16(8'h2A, 16'hFFFF);
    pad_i = '0; tick(4);
    rd16(8'h2A, r);
    check("R7 fall ignored", r, 16'h0);
    pad_i = 10'h3FF; tick(4);

    // R12 enable gating
    wr16(8'h26, img(10'h001));
    check("R12 irq on", {15'b0, irq_o}, 16'h1);

    // R10 write zero / partial byte clear
    wr16(8'h2A, 16'h0000);
    rd16(8'h2A, r);
    check("R10 zero write", r, 16'h07FE);
    wr(8'h2A, 8'hFF);
    rd16(8'h2A, r);
    check("R10 low clear", r, 16'h0700);
    check("R12 irq off", {15'b0, irq_o}, 16'h0);
    wr(8'h2B, 8'hFF);

    // R8 both edges, random sequence
    wr16(8'h28, 16'hFFFF);
    wr16(8'h26, 16'hFFFF);
    pad_i = '0; tick(4);
    wr16(8'h2A, 16'hFFFF);
    exp_st = '0;
    q = '0;
    for (int i = 0; i < 20; i++) begin
      p = NPIN'($urandom);
      pad_i = p; tick(4);
      exp_st |= p ^ q;
      q = p;
      rd16(8'h2A, r);
      check("R8 both", r, img(exp_st));
      check("R12 irq", {15'b0, irq_o}, {15'b0, exp_st != '0});
      if (i % 5 == 4) begin
        wr16(8'h2A, img(exp_st));
        exp_st = '0;
      end
    end

    // R11 event and clear coincide
    pad_i = '0; tick(4);
    wr16(8'h2A, 16'hFFFF);
    pad_i[0] = 1'b1; tick(4);
    pad_i[0] = 1'b0;
    tick(2);
    wr(8'h2A, 8'h02);   // lands with the falling-edge event
    rd16(8'h2A, r);
    check("R11 event wins", r, 16'h0002);
    wr(8'h2A, 8'h02);
    rd16(8'h2A, r);
    check("R10 clear", r, 16'h0000);

    done();
  end
endmodule